// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

One channel of an 8-bit down-counting counter/timer that the CPU programs through a single byte-wide write port. A written byte with bit 0 set is a control word: it sets the mode, the prescaler ratio, the trigger edge, the start rule and the interrupt enable. It can also stop the channel or announce that a time-constant byte comes next. A byte with bit 0 clear is stored as an interrupt vector. The channel uses a time constant of 0 as 256.

In timer mode the system clock runs through a prescaler of 16 or 256 before each decrement. Counting starts either as soon as the time constant is loaded or on the first active edge of the clock/trigger input. In counter mode each active edge of that input decrements the counter. The input is synchronised by two flops before edge detection. When the count steps from 1 to 0, the channel pulses its zero-count output for one clock and reloads the time constant in that same clock. It also sets its interrupt request if interrupts are enabled. Typical uses are interval timing, event counting and generating a baud-rate clock from the zero-count pulse.

Top module: `ctc_channel`

## Requirements
- R1: After reset, count_o, vector_o, zc_o and irq_o are all 0 and the channel is stopped, with no time constant stored.
- R2: A write with bit 0 = 0 (when no time constant is pending) stores the byte in the vector register, shown on vector_o from the next clock, and does not disturb counting. A write with bit 0 = 1 is a control word with fields: bit 7 interrupt enable, bit 6 mode (0 timer, 1 counter), bit 5 prescaler (1 = 256, 0 = 16), bit 4 edge (1 rising, 0 falling), bit 3 timer start (0 automatic, 1 on trigger), bit 2 time constant follows, bit 1 software stop.
- R3: A control word with bit 2 set stops the channel. The next write, whatever its bit 0, is taken as the time constant and appears on count_o one clock later.
- R4: In timer mode with the prescaler field 0, the count drops by one every 16 clocks, the first drop 16 clocks after the load. With the field 1, the interval is 256 clocks.
- R5: In counter mode, each active edge of trig_i decrements the count at the third rising clock edge after the pin changes. Edges of the other polarity are ignored.
- R6: In timer mode with bit 3 set, the channel stays stopped after the time-constant load until an active edge on trig_i arrives. The prescaler then starts from zero.
- R7: When the count steps from 1 to 0, zc_o is high for exactly one clock and count_o shows the reloaded time constant in that same clock.
- R8: irq_o rises together with zc_o when interrupts are enabled and stays high until irq_ack_i is sampled high. A new terminal count in the same clock keeps it set.
- R9: A control word with bit 1 set stops counting and freezes count_o, but keeps the stored time constant. A later control word with bits 1 and 2 clear reloads the count from that constant and starts again under the timer start rule.
- R10: A time constant of 0 gives 256 decrements between terminal counts.
- R11: While the channel is stopped and no write occurs, count_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | CPU write strobe, one byte per clock |
| wr_data_i | input | 8 | CPU write data |
| irq_ack_i | input | 1 | Clears the interrupt request |
| trig_i | input | 1 | Asynchronous clock/trigger input |
| zc_o | output | 1 | One-clock terminal-count pulse |
| irq_o | output | 1 | Interrupt request |
| count_o | output | 8 | Current down-counter value (0 stands for 256) |
| vector_o | output | 8 | Stored interrupt vector |

## Verification
The hardest situation to reach is the trigger-started timer. The channel must ignore edges of the wrong polarity, start on the first right one, and then time its prescaler from the start rather than from the load. To get there, the stimulus loads a constant with the trigger rule set and idles well past one prescaler period. It then raises trig_i, which the falling-edge setting must ignore, and only then drops it. The count is checked at each step. A second hard case is the stop-and-resume path. The bench halts a running timer in mid-count and holds it there. It then resumes with a bare control word, which shows that the stored constant survived.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int unsigned BYTE_W = 8;

    // control word field positions
    localparam int unsigned B_IS_CTRL  = 0;
    localparam int unsigned B_STOP     = 1;
    localparam int unsigned B_TC_NEXT  = 2;
    localparam int unsigned B_WAIT_TRG = 3;
    localparam int unsigned B_RISE     = 4;
    localparam int unsigned B_LONG_PRE = 5;
    localparam int unsigned B_CNT_MODE = 6;
    localparam int unsigned B_IRQ_EN   = 7;

    typedef struct packed {
        logic irq_en;
        logic cnt_mode;
        logic long_pre;
        logic rise;
        logic wait_trg;
    } ctc_cfg_t;

    typedef struct packed {
        logic     is_tc;
        logic     is_ctrl;
        logic     is_vec;
        logic     do_stop;
        logic     do_tc_next;
        logic     bare_ctrl;
        ctc_cfg_t cfg;
    } ctc_wr_t;

    typedef struct packed {
        ctc_cfg_t          cfg;
        logic [BYTE_W-1:0] tc;
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] vec;
        logic              run;
        logic              armed;
        logic              tc_pend;
        logic              have_tc;
        logic              zc;
        logic              irq;
    } ctc_state_t;

endpackage

// File: rtl/ctc_sync_edge.sv
module ctc_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                assign sync_d[i] = async_i;
            end else begin : g_next
                assign sync_d[i] = sync_q[i-1];
            end
        end
    endgenerate

    always_comb begin
        prev_d = sync_q[LAST];
        if (rise_sel_i) begin
            edge_o = sync_q[LAST] & ~prev_q;
        end else begin
            edge_o = ~sync_q[LAST] & prev_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
    parameter int unsigned SHORT_DIV = 16,
    parameter int unsigned LONG_DIV  = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    input  logic long_i,
    output logic tick_o
);
    localparam int unsigned PW = $clog2(LONG_DIV);
    localparam logic [PW-1:0] SHORT_LAST = PW'(SHORT_DIV - 1);
    localparam logic [PW-1:0] LONG_LAST  = PW'(LONG_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit  = long_i ? LONG_LAST : SHORT_LAST;
        tick_o = en_i && (pre_q == limit);
        pre_d  = pre_q;
        if (clear_i) begin
            pre_d = '0;
        end else if (en_i) begin
            pre_d = tick_o ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end
endmodule

// File: rtl/ctc_wr_decode.sv
module ctc_wr_decode
    import ctc_pkg::*;
(
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              tc_pend_i,
    output ctc_wr_t           wr_o
);
    always_comb begin
        wr_o              = '0;
        wr_o.cfg.irq_en   = data_i[B_IRQ_EN];
        wr_o.cfg.cnt_mode = data_i[B_CNT_MODE];
        wr_o.cfg.long_pre = data_i[B_LONG_PRE];
        wr_o.cfg.rise     = data_i[B_RISE];
        wr_o.cfg.wait_trg = data_i[B_WAIT_TRG];
        if (wr_en_i) begin
            if (tc_pend_i) begin
                wr_o.is_tc = 1'b1;
            end else if (data_i[B_IS_CTRL]) begin
                wr_o.is_ctrl    = 1'b1;
                wr_o.do_stop    = data_i[B_STOP];
                wr_o.do_tc_next = data_i[B_TC_NEXT];
                wr_o.bare_ctrl  = !data_i[B_STOP] && !data_i[B_TC_NEXT];
            end else begin
                wr_o.is_vec = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
    import ctc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SHORT_DIV   = 16,
    parameter int unsigned LONG_DIV    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              irq_ack_i,
    input  logic              trig_i,
    output logic              zc_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] count_o,
    output logic [BYTE_W-1:0] vector_o
);
    localparam logic [BYTE_W-1:0] CNT_ONE = BYTE_W'(1);

    ctc_state_t state_d, state_q;
    ctc_wr_t    wr;
    logic       trg_edge;
    logic       pre_tick;
    logic       pre_clear;
    logic       pre_en;
    logic       step;
    logic       takeover;
    logic       restart;

    ctc_wr_decode u_dec (
        .wr_en_i   (wr_en_i),
        .data_i    (wr_data_i),
        .tc_pend_i (state_q.tc_pend),
        .wr_o      (wr)
    );

    ctc_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_i    (trig_i),
        .rise_sel_i (state_q.cfg.rise),
        .edge_o     (trg_edge)
    );

    ctc_prescaler #(
        .SHORT_DIV (SHORT_DIV),
        .LONG_DIV  (LONG_DIV)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pre_clear),
        .en_i    (pre_en),
        .long_i  (state_q.cfg.long_pre),
        .tick_o  (pre_tick)
    );

    always_comb begin
        restart   = wr.is_ctrl && wr.bare_ctrl && !state_q.run
                    && !state_q.armed && state_q.have_tc;
        takeover  = wr.is_tc || (wr.is_ctrl && (wr.do_stop || wr.do_tc_next)) || restart;
        pre_en    = state_q.run && !state_q.cfg.cnt_mode;
        pre_clear = takeover;
        step      = state_q.run && (state_q.cfg.cnt_mode ? trg_edge : pre_tick) && !takeover;

        state_d    = state_q;
        state_d.zc = 1'b0;

        // trigger-started timer
        if (state_q.armed && trg_edge) begin
            state_d.run   = 1'b1;
            state_d.armed = 1'b0;
        end

        // down-count and terminal count
        if (step) begin
            if (state_q.cnt == CNT_ONE) begin
                state_d.cnt = state_q.tc;
                state_d.zc  = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt - 1'b1;
            end
        end

        state_d.irq = (state_q.irq && !irq_ack_i)
                    || (step && state_q.cnt == CNT_ONE && state_q.cfg.irq_en);

        // CPU writes
        if (wr.is_vec) begin
            state_d.vec = wr_data_i;
        end
        if (wr.is_ctrl) begin
            state_d.cfg = wr.cfg;
        end
        if (wr.is_ctrl && wr.do_stop) begin
            state_d.run   = 1'b0;
            state_d.armed = 1'b0;
        end
        if (wr.is_ctrl && wr.do_tc_next) begin
            state_d.run     = 1'b0;
            state_d.armed   = 1'b0;
            state_d.tc_pend = 1'b1;
        end
        if (wr.is_tc) begin
            state_d.tc      = wr_data_i;
            state_d.cnt     = wr_data_i;
            state_d.tc_pend = 1'b0;
            state_d.have_tc = 1'b1;
            state_d.run     = state_q.cfg.cnt_mode || !state_q.cfg.wait_trg;
            state_d.armed   = !state_q.cfg.cnt_mode && state_q.cfg.wait_trg;
        end
        if (restart) begin
            state_d.cnt   = state_q.tc;
            state_d.run   = wr.cfg.cnt_mode || !wr.cfg.wait_trg;
            state_d.armed = !wr.cfg.cnt_mode && wr.cfg.wait_trg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign zc_o     = state_q.zc;
    assign irq_o    = state_q.irq;
    assign count_o  = state_q.cnt;
    assign vector_o = state_q.vec;

endmodule

// File: rtl/ctc_channel_chk.sv
module ctc_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       irq_ack_i,
    input logic       zc_o,
    input logic       irq_o,
    input logic [7:0] count_o,
    input logic [7:0] vector_o,
    input logic       run_i,
    input logic       tc_pend_i
);
    p_zc_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zc_o |=> !zc_o);

    p_irq_with_zc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> zc_o);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_ack_i) |=> irq_o);

    p_vector_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !tc_pend_i && !wr_data_i[0]) |=> (vector_o == $past(wr_data_i)));

    p_tc_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && tc_pend_i) |=> (count_o == $past(wr_data_i)));

    p_stopped_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_en_i) |=> $stable(count_o));

    p_step_by_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wr_en_i) |=> (zc_o || count_o == $past(count_o)
                                 || count_o == $past(count_o) - 8'd1));
endmodule

bind ctc_channel ctc_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .irq_ack_i (irq_ack_i),
    .zc_o      (zc_o),
    .irq_o     (irq_o),
    .count_o   (count_o),
    .vector_o  (vector_o),
    .run_i     (state_q.run),
    .tc_pend_i (state_q.tc_pend)
);

// File: tb/ctc_channel_bench.sv
module ctc_channel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       irq_ack_i = 1'b0;
    logic       trig_i = 1'b0;
    logic       zc_o, irq_o;
    logic [7:0] count_o, vector_o;

    int checks = 0;
    int failures = 0;
    int zc_seen = 0;
    bit done = 1'b0;
    bit cmp_en = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    ctc_channel u_ctc_channel (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .irq_ack_i(irq_ack_i), .trig_i(trig_i), .zc_o(zc_o), .irq_o(irq_o),
        .count_o(count_o), .vector_o(vector_o)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_tc, m_vec, m_pre;
    bit m_run, m_armed, m_pend, m_have, m_zc, m_irq;
    bit m_ien, m_cmode, m_long, m_rise, m_wait;
    bit m_s1, m_s2, m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tc = 0; m_vec = 0; m_pre = 0;
            m_run = 0; m_armed = 0; m_pend = 0; m_have = 0; m_zc = 0; m_irq = 0;
            m_ien = 0; m_cmode = 0; m_long = 0; m_rise = 0; m_wait = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            bit edge_now, tick, stepping, take, set_irq, is_ctrl;
            int ratio;
            edge_now = m_rise ? (m_s2 && !m_prev) : (!m_s2 && m_prev);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = trig_i;
            ratio = m_long ? 256 : 16;
            tick = m_run && !m_cmode && (m_pre == ratio - 1);
            is_ctrl = wr_en_i && !m_pend && wr_data_i[0];
            take = (wr_en_i && m_pend)
                || (is_ctrl && (wr_data_i[1] || wr_data_i[2]))
                || (is_ctrl && !m_run && !m_armed && m_have);
            stepping = m_run && (m_cmode ? edge_now : tick) && !take;
            if (take) m_pre = 0;
            else if (m_run && !m_cmode) m_pre = tick ? 0 : m_pre + 1;
            set_irq = stepping && m_cnt == 1 && m_ien;
            m_irq = (m_irq && !irq_ack_i) || set_irq;
            m_zc = 0;
            if (m_armed && edge_now) begin m_run = 1; m_armed = 0; end
            if (stepping) begin
                if (m_cnt == 1) begin m_cnt = m_tc; m_zc = 1; end
                else m_cnt = (m_cnt + 255) % 256;
            end
            if (wr_en_i && m_pend) begin
                m_tc = wr_data_i; m_cnt = wr_data_i; m_pend = 0; m_have = 1;
                m_run = m_cmode || !m_wait; m_armed = !m_cmode && m_wait;
            end else if (wr_en_i && !wr_data_i[0]) begin
                m_vec = wr_data_i;
            end else if (is_ctrl) begin
                bit restart;
                restart = !wr_data_i[1] && !wr_data_i[2] && !m_run && !m_armed && m_have;
                m_ien = wr_data_i[7]; m_cmode = wr_data_i[6]; m_long = wr_data_i[5];
                m_rise = wr_data_i[4]; m_wait = wr_data_i[3];
                if (wr_data_i[1]) begin m_run = 0; m_armed = 0; end
                if (wr_data_i[2]) begin m_run = 0; m_armed = 0; m_pend = 1; end
                if (restart) begin
                    m_cnt = m_tc;
                    m_run = m_cmode || !m_wait; m_armed = !m_cmode && m_wait;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (zc_o) zc_seen++;
        if (cmp_en && rst_n && !done) begin
            chk(count_o == m_cnt[7:0], {phase, " model count"}, count_o, m_cnt);
            chk(zc_o == m_zc, "R7 model zc", zc_o, m_zc);
            chk(irq_o == m_irq, "R8 model irq", irq_o, m_irq);
            chk(vector_o == m_vec[7:0], "R2 model vector", vector_o, m_vec);
        end
    end

    task automatic wr(input logic [7:0] b);
        @(negedge clk); wr_en_i = 1'b1; wr_data_i = b;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        trig_i = 1'b1; idle(4);
        trig_i = 1'b0; idle(4);
    endtask

    task automatic wait_zc(input int limit);
        for (int i = 0; i < limit && !zc_o; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int z0;
        idle(3);
        // R1: reset state
        chk(count_o == 0 && vector_o == 0, "R1 reset count/vector", count_o, 0);
        chk(!zc_o && !irq_o, "R1 reset zc/irq", {zc_o, irq_o}, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        idle(2);

        // R2 vector, R11 stays stopped
        phase = "R11";
        wr(8'hA4);
        chk(vector_o == 8'hA4, "R2 vector store", vector_o, 8'hA4);
        idle(20);
        chk(count_o == 0, "R11 stopped without tc", count_o, 0);

        // R3/R4 timer short prescale with irq
        phase = "R4";
        wr(8'h85);
        wr(8'h03);
        chk(count_o == 3, "R3 tc load visible", count_o, 3);
        idle(10);
        chk(count_o == 3, "R4 no drop before 16", count_o, 3);
        idle(10);
        chk(count_o == 2, "R4 drop after 16", count_o, 2);
        wait_zc(100);
        chk(zc_o && count_o == 3, "R7 reload at zc", count_o, 3);
        chk(irq_o, "R8 irq with zc", irq_o, 1);
        idle(1);
        chk(!zc_o, "R7 zc single clock", zc_o, 0);
        idle(5);
        chk(irq_o, "R8 irq held", irq_o, 1);
        wr(8'hF6);
        chk(vector_o == 8'hF6, "R2 vector while running", vector_o, 8'hF6);
        @(negedge clk); irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
        chk(!irq_o, "R8 ack clears", irq_o, 0);

        // R9 software stop and resume
        phase = "R9";
        idle(7);
        wr(8'h03);
        begin
            logic [7:0] held;
            held = count_o;
            idle(40);
            chk(count_o == held, "R9 count frozen", count_o, held);
        end
        wr(8'h01);
        chk(count_o == 3, "R9 resume from kept tc", count_o, 3);
        idle(60);

        // R4 long prescale
        phase = "R4";
        wr(8'h25);
        wr(8'h02);
        idle(250);
        chk(count_o == 2, "R4 long no drop before 256", count_o, 2);
        idle(10);
        chk(count_o == 1, "R4 long drop after 256", count_o, 1);
        idle(300);

        // R5/R10 counter mode rising, tc 0
        phase = "R10";
        wr(8'h55);
        wr(8'h00);
        chk(count_o == 0, "R10 tc zero loaded", count_o, 0);
        z0 = zc_seen;
        pulse();
        chk(count_o == 255, "R5 rising edge counted", count_o, 255);
        for (int i = 0; i < 254; i++) pulse();
        chk(count_o == 1 && zc_seen == z0, "R10 no zc before 256", count_o, 1);
        pulse();
        chk(count_o == 0 && zc_seen == z0 + 1, "R10 zc after 256 edges", zc_seen - z0, 1);

        // R5 falling edge
        phase = "R5";
        wr(8'h45);
        wr(8'h05);
        trig_i = 1'b1; idle(5);
        chk(count_o == 5, "R5 rising ignored", count_o, 5);
        trig_i = 1'b0; idle(2);
        chk(count_o == 5, "R5 not yet at second clock", count_o, 5);
        idle(1);
        chk(count_o == 4, "R5 falling counted at third clock", count_o, 4);
        pulse(); pulse();
        chk(count_o == 2, "R5 falling edges", count_o, 2);

        // R6 trigger-started timer
        phase = "R6";
        wr(8'h8D);
        wr(8'h02);
        idle(40);
        chk(count_o == 2, "R6 waits for trigger", count_o, 2);
        trig_i = 1'b1; idle(30);
        chk(count_o == 2, "R6 wrong edge no start", count_o, 2);
        trig_i = 1'b0; idle(10);
        chk(count_o == 2, "R6 prescaler from start", count_o, 2);
        idle(15);
        chk(count_o == 1, "R6 counting after trigger", count_o, 1);
        wait_zc(100);
        chk(zc_o && irq_o, "R8 irq on triggered zc", irq_o, 1);
        idle(20);

        finish_run();
    end
endmodule